// File: doc/BRIEF.md
# Byte ALU with Status Flags

The block is the arithmetic and logic stage of a small 8-bit processor core. On each cycle it takes two data bytes and an operation code and computes the result byte with no clock in between. It also gives a candidate value for each of six status flags and a mask that marks which of those flags the operation is allowed to change. A six-bit status register inside the block merges the candidate flags through that mask on the clock edge where an operation is accepted. The carry and zero inputs of chained operations come from this register.

A second class of operation adds an unsigned immediate to a 16-bit register pair, or subtracts it from the pair. The block runs this through the same byte adder in two passes: the low byte on the accepting cycle, then the high byte with the saved carry on the next cycle. It reports the 16-bit result and updates the flags when the second pass ends. Register file access, instruction decode and multiplication are handled elsewhere. Immediate forms of the byte operations (subtract constant, AND/OR with constant, set bits) use the same codes as their register forms, with the constant driven on the second operand.

Top module: `flag_alu`

## Requirements
- R1: Code 0 computes opA+opB and code 1 computes opA+opB+C. Both update all six flags. C is the carry out of bit 7, H is the carry out of bit 3, V is the signed overflow, N is result bit 7, Z is set when the result is zero, and S is N XOR V.
- R2: Code 2 computes opA-opB and code 3 computes opA-opB-C. Both update all six flags. C is the borrow out of bit 7 and H is the borrow into bit 4. For code 3, Z is set only when the result is zero and Z was already set; for code 2, Z is set when the result is zero.
- R3: The logic codes give these results: 4 gives opA AND opB, 5 gives opA OR opB, 6 gives opA XOR opB, 7 gives opA AND NOT opB, 8 passes opA, and 9 gives zero. Each updates Z, N, V and S, forces V to 0, and leaves C and H unchanged.
- R4: Code 10 gives 0xFF minus opA. It sets C to 1 and V to 0, updates Z, N and S, and leaves H unchanged.
- R5: Code 11 gives 0x00 minus opA and updates all six flags. C is set when the result is nonzero, H is set when the low nibble of opA is nonzero, and V is set only for a result of 0x80.
- R6: Code 12 gives opA+1 with V set only when opA is 0x7F. Code 13 gives opA-1 with V set only when opA is 0x80. Both update Z, N, V and S and never change C or H.
- R7: Code 14 gives 0xFF and leaves every flag unchanged.
- R8: In the status register, S always equals N XOR V.
- R9: Flag bit positions in newFlags, flagMask and status are C=0, Z=1, N=2, V=3, S=4, H=5. flagMask is 0x3F for codes 0–3 and 11, 0x1E for codes 4–9, 12 and 13, 0x1F for codes 10, 15 and 16, and 0x00 for code 14. On an edge that accepts a byte operation, status takes newFlags in masked bits and holds the other bits. Reset clears status, busy, wordDone and wordResult.
- R10: Code 15 adds wordImm to the pair {opB,opA} and code 16 subtracts wordImm from it. After the accepting edge, busy is high for exactly one cycle. The second edge loads wordResult, clears busy and raises wordDone for one cycle. Status does not change on the accepting edge.
- R11: At the end of a word operation, status gets the following values. Z is set when the 16-bit result is zero. C is the 16-bit carry for code 15 or the 16-bit borrow for code 16. N is result bit 15, V is the 16-bit signed overflow, and S is N XOR V. H is unchanged.
- R12: An opValid presented while busy is high is ignored. Codes 17 to 31 give result 0 and mask 0x00 and leave status unchanged.
- R13: With opValid low and the block idle, status does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Accept the presented operation on this edge |
| opSel | input | 5 | Operation code |
| opA | input | 8 | First operand, or low byte of the word pair |
| opB | input | 8 | Second operand or constant, or high byte of the word pair |
| wordImm | input | 6 | Unsigned immediate for word operations |
| result | output | 8 | Combinational result byte |
| newFlags | output | 6 | Candidate flag values |
| flagMask | output | 6 | Flags the presented operation may change |
| status | output | 6 | Registered status flags |
| busy | output | 1 | Second pass of a word operation in progress |
| wordResult | output | 16 | Result of the last completed word operation |
| wordDone | output | 1 | One-cycle pulse after a word operation ends |

## Verification
result, newFlags and flagMask are due in the same cycle the inputs change. The bench drives inputs on the falling edge and samples these outputs one nanosecond later. status is due one rising edge after acceptance and is sampled one nanosecond after that edge. For a word operation, busy is checked after the first edge, and wordResult, wordDone and the flags are checked after the second edge. A further edge with opValid low then confirms that wordDone has dropped and status has held.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_EOR  = 5'd6,
    OP_CBR  = 5'd7,
    OP_TST  = 5'd8,
    OP_CLR  = 5'd9,
    OP_COM  = 5'd10,
    OP_NEG  = 5'd11,
    OP_INC  = 5'd12,
    OP_DEC  = 5'd13,
    OP_SER  = 5'd14,
    OP_WADD = 5'd15,
    OP_WSUB = 5'd16
  } opcode_e;

  // bit order: h s v n z c  ->  positions 5..0
  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  typedef enum logic [2:0] {
    ARG_AB, // x = opA, y = opB
    ARG_AA, // x = opA, y = opA
    ARG_ZA, // x = 0,   y = opA
    ARG_A1, // x = opA, y = 1
    ARG_AI, // x = opA, y = immediate
    ARG_H0  // x = held high byte, y = 0
  } argSel_e;

  typedef enum logic [2:0] {
    RES_ARITH,
    RES_AND,
    RES_OR,
    RES_XOR,
    RES_ANDN,
    RES_NOT,
    RES_ONES
  } resSrc_e;

  typedef struct packed {
    argSel_e argSel;
    resSrc_e resSrc;
    logic    doSub;
    logic    carryIn;
    logic    chainZ;
    logic    zeroIn;
    logic    forceCarry;
  } strobes_t;

  localparam logic [5:0] MASK_ALL   = 6'h3F;
  localparam logic [5:0] MASK_LOGIC = 6'h1E;
  localparam logic [5:0] MASK_COM   = 6'h1F;
  localparam logic [5:0] MASK_WORD  = 6'h1F;
  localparam logic [5:0] MASK_NONE  = 6'h00;

endpackage

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 6
) (
  input  strobes_t              ctl,
  input  logic [DATA_W-1:0]     opA,
  input  logic [DATA_W-1:0]     opB,
  input  logic [DATA_W-1:0]     heldHi,
  input  logic [IMM_W-1:0]      wordImm,
  output logic [DATA_W-1:0]     result,
  output flags_t                flags
);

  localparam int HALF_BIT = DATA_W / 2;
  localparam int MSB      = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] argX;
  logic [DATA_W-1:0] argY;
  logic [DATA_W-1:0] addend;
  logic [DATA_W-1:0] immExt;
  logic [DATA_W:0]   sum;
  logic              cAdd;
  logic              carryHalf;
  logic              carryMsb;
  logic              overflow;

  assign immExt = {{(DATA_W-IMM_W){1'b0}}, wordImm};

  always_comb begin
    case (ctl.argSel)
      ARG_AA:  begin argX = opA;    argY = opA;    end
      ARG_ZA:  begin argX = '0;     argY = opA;    end
      ARG_A1:  begin argX = opA;    argY = ONE;    end
      ARG_AI:  begin argX = opA;    argY = immExt; end
      ARG_H0:  begin argX = heldHi; argY = '0;     end
      default: begin argX = opA;    argY = opB;    end
    endcase
  end

  // subtraction as x + ~y + ~borrowIn
  assign addend = ctl.doSub ? ~argY : argY;
  assign cAdd   = ctl.doSub ^ ctl.carryIn;
  assign sum    = {1'b0, argX} + {1'b0, addend} + {{DATA_W{1'b0}}, cAdd};

  // carry into a bit position recovered from the sum bit
  assign carryHalf = argX[HALF_BIT] ^ addend[HALF_BIT] ^ sum[HALF_BIT];
  assign carryMsb  = argX[MSB] ^ addend[MSB] ^ sum[MSB];
  assign overflow  = carryMsb ^ sum[DATA_W];

  always_comb begin
    case (ctl.resSrc)
      RES_AND:  result = argX & argY;
      RES_OR:   result = argX | argY;
      RES_XOR:  result = argX ^ argY;
      RES_ANDN: result = argX & ~argY;
      RES_NOT:  result = ~argX;
      RES_ONES: result = '1;
      default:  result = sum[DATA_W-1:0];
    endcase
  end

  always_comb begin
    flags.c = ctl.forceCarry | (ctl.doSub ? ~sum[DATA_W] : sum[DATA_W]);
    flags.h = ctl.doSub ? ~carryHalf : carryHalf;
    flags.v = (ctl.resSrc == RES_ARITH) & overflow;
    flags.n = result[MSB];
    flags.z = (result == '0) & (~ctl.chainZ | ctl.zeroIn);
    flags.s = flags.n ^ flags.v;
  end

endmodule

// File: rtl/flag_alu_ctl.sv
module flag_alu_ctl
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opValid,
  input  logic [OP_W-1:0]       opSel,
  input  logic [DATA_W-1:0]     opB,
  input  logic [DATA_W-1:0]     dpResult,
  input  flags_t                dpFlags,
  output strobes_t              ctl,
  output logic [DATA_W-1:0]     heldHi,
  output logic [5:0]            flagMask,
  output flags_t                status,
  output logic                  busy,
  output logic [2*DATA_W-1:0]   wordResult,
  output logic                  wordDone
);

  flags_t              statusQ;
  flags_t              nextStatus;
  logic [5:0]          maskBits;
  logic                busyQ;
  logic                wordSubQ;
  logic                savedC;
  logic                loZero;
  logic [DATA_W-1:0]   heldHiQ;
  logic [DATA_W-1:0]   loResQ;
  logic [2*DATA_W-1:0] wordResQ;
  logic                doneQ;
  logic                accept;
  logic                isWord;

  assign accept = opValid & ~busyQ;
  assign isWord = (opSel == OP_WADD) || (opSel == OP_WSUB);

  always_comb begin
    ctl.argSel     = ARG_AB;
    ctl.resSrc     = RES_ARITH;
    ctl.doSub      = 1'b0;
    ctl.carryIn    = 1'b0;
    ctl.chainZ     = 1'b0;
    ctl.zeroIn     = statusQ.z;
    ctl.forceCarry = 1'b0;
    maskBits       = MASK_NONE;
    if (busyQ) begin
      // second pass: high byte plus saved carry, zero chained from low byte
      ctl.argSel  = ARG_H0;
      ctl.doSub   = wordSubQ;
      ctl.carryIn = savedC;
      ctl.chainZ  = 1'b1;
      ctl.zeroIn  = loZero;
      maskBits    = MASK_WORD;
    end else begin
      case (opSel)
        OP_ADD: maskBits = MASK_ALL;
        OP_ADC: begin ctl.carryIn = statusQ.c; maskBits = MASK_ALL; end
        OP_SUB: begin ctl.doSub = 1'b1; maskBits = MASK_ALL; end
        OP_SBC: begin
          ctl.doSub   = 1'b1;
          ctl.carryIn = statusQ.c;
          ctl.chainZ  = 1'b1;
          maskBits    = MASK_ALL;
        end
        OP_AND: begin ctl.resSrc = RES_AND;  maskBits = MASK_LOGIC; end
        OP_OR:  begin ctl.resSrc = RES_OR;   maskBits = MASK_LOGIC; end
        OP_EOR: begin ctl.resSrc = RES_XOR;  maskBits = MASK_LOGIC; end
        OP_CBR: begin ctl.resSrc = RES_ANDN; maskBits = MASK_LOGIC; end
        OP_TST: begin
          ctl.argSel = ARG_AA; ctl.resSrc = RES_AND; maskBits = MASK_LOGIC;
        end
        OP_CLR: begin
          ctl.argSel = ARG_AA; ctl.resSrc = RES_XOR; maskBits = MASK_LOGIC;
        end
        OP_COM: begin
          ctl.resSrc = RES_NOT; ctl.forceCarry = 1'b1; maskBits = MASK_COM;
        end
        OP_NEG: begin ctl.argSel = ARG_ZA; ctl.doSub = 1'b1; maskBits = MASK_ALL; end
        OP_INC: begin ctl.argSel = ARG_A1; maskBits = MASK_LOGIC; end
        OP_DEC: begin ctl.argSel = ARG_A1; ctl.doSub = 1'b1; maskBits = MASK_LOGIC; end
        OP_SER: begin ctl.resSrc = RES_ONES; maskBits = MASK_NONE; end
        OP_WADD: begin ctl.argSel = ARG_AI; maskBits = MASK_WORD; end
        OP_WSUB: begin ctl.argSel = ARG_AI; ctl.doSub = 1'b1; maskBits = MASK_WORD; end
        default: begin
          ctl.argSel = ARG_AA; ctl.resSrc = RES_XOR; maskBits = MASK_NONE;
        end
      endcase
    end
  end

  assign nextStatus = flags_t'((dpFlags & maskBits) | (statusQ & ~maskBits));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      busyQ    <= 1'b0;
      wordSubQ <= 1'b0;
      savedC   <= 1'b0;
      loZero   <= 1'b0;
      heldHiQ  <= '0;
      loResQ   <= '0;
      wordResQ <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= busyQ;
      if (busyQ) begin
        busyQ    <= 1'b0;
        statusQ  <= nextStatus;
        wordResQ <= {dpResult, loResQ};
      end else if (accept) begin
        if (isWord) begin
          busyQ    <= 1'b1;
          wordSubQ <= (opSel == OP_WSUB);
          savedC   <= dpFlags.c;
          loZero   <= dpFlags.z;
          heldHiQ  <= opB;
          loResQ   <= dpResult;
        end else begin
          statusQ <= nextStatus;
        end
      end
    end
  end

  assign heldHi     = heldHiQ;
  assign flagMask   = maskBits;
  assign status     = statusQ;
  assign busy       = busyQ;
  assign wordResult = wordResQ;
  assign wordDone   = doneQ;

  logic [5:0] statusBits;
  assign statusBits = statusQ;

  assert_word_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !busyQ && isWord) |=> (busyQ && $stable(statusBits)));

  assert_busy_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |=> (!busyQ && doneQ));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  assert_unmasked_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !busyQ && !isWord) |=>
      ((statusBits & ~$past(maskBits)) == ($past(statusBits) & ~$past(maskBits))));

  assert_idle_stable_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !busyQ) |=> $stable(statusBits));

  assert_sign_rule_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusQ.s == (statusQ.n ^ statusQ.v));

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [OP_W-1:0]     opSel,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [IMM_W-1:0]    wordImm,
  output logic [DATA_W-1:0]   result,
  output logic [5:0]          newFlags,
  output logic [5:0]          flagMask,
  output logic [5:0]          status,
  output logic                busy,
  output logic [2*DATA_W-1:0] wordResult,
  output logic                wordDone
);

  strobes_t          ctlW;
  flags_t            dpFlagsW;
  flags_t            statusW;
  logic [DATA_W-1:0] heldHiW;
  logic [DATA_W-1:0] dpResultW;

  flag_alu_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .opValid    (opValid),
    .opSel      (opSel),
    .opB        (opB),
    .dpResult   (dpResultW),
    .dpFlags    (dpFlagsW),
    .ctl        (ctlW),
    .heldHi     (heldHiW),
    .flagMask   (flagMask),
    .status     (statusW),
    .busy       (busy),
    .wordResult (wordResult),
    .wordDone   (wordDone)
  );

  flag_alu_dp #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .ctl     (ctlW),
    .opA     (opA),
    .opB     (opB),
    .heldHi  (heldHiW),
    .wordImm (wordImm),
    .result  (dpResultW),
    .flags   (dpFlagsW)
  );

  assign result   = dpResultW;
  assign newFlags = dpFlagsW;
  assign status   = statusW;

endmodule

// File: tb/flag_alu_bench.sv
`timescale 1ns/100ps
module flag_alu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opSel = '0;
  logic [7:0]  opA = '0;
  logic [7:0]  opB = '0;
  logic [5:0]  wordImm = '0;
  logic [7:0]  result;
  logic [5:0]  newFlags;
  logic [5:0]  flagMask;
  logic [5:0]  status;
  logic        busy;
  logic [15:0] wordResult;
  logic        wordDone;

  int   vectors = 0;
  int   miscompares = 0;
  bit   finished = 1'b0;
  logic [5:0] st = '0;

  always #2.5 clk = ~clk;

  flag_alu u_flag_alu (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .opA(opA), .opB(opB), .wordImm(wordImm), .result(result),
    .newFlags(newFlags), .flagMask(flagMask), .status(status),
    .busy(busy), .wordResult(wordResult), .wordDone(wordDone)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input int op);
    case (op)
      0, 1:             return "R1";
      2, 3:             return "R2";
      4, 5, 6, 7, 8, 9: return "R3";
      10:               return "R4";
      11:               return "R5";
      12, 13:           return "R6";
      14:               return "R7";
      default:          return "R12";
    endcase
  endfunction

  function automatic int sgn8(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // independent arithmetic model; flags packed h s v n z c
  task automatic model(input int op, input int a, input int b, input logic [5:0] s0,
                       output int r, output logic [5:0] f, output logic [5:0] m);
    int t, sv, ci;
    logic c, h, v, z, n, zChain;
    c = 1'b0; h = 1'b0; v = 1'b0; zChain = 1'b1; r = 0; m = 6'h00;
    ci = int'(s0[0]);
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        t = a + b + ci; r = t & 255; c = (t > 255);
        h = (((a & 15) + (b & 15) + ci) > 15);
        sv = sgn8(a) + sgn8(b) + ci; v = (sv > 127) || (sv < -128);
        m = 6'h3F;
      end
      2, 3: begin
        if (op == 2) ci = 0;
        t = a - b - ci; r = t & 255; c = (t < 0);
        h = (((a & 15) - (b & 15) - ci) < 0);
        sv = sgn8(a) - sgn8(b) - ci; v = (sv > 127) || (sv < -128);
        if (op == 3) zChain = s0[1];
        m = 6'h3F;
      end
      4:  begin r = a & b;         m = 6'h1E; end
      5:  begin r = a | b;         m = 6'h1E; end
      6:  begin r = a ^ b;         m = 6'h1E; end
      7:  begin r = a & (255 - b); m = 6'h1E; end
      8:  begin r = a;             m = 6'h1E; end
      9:  begin r = 0;             m = 6'h1E; end
      10: begin r = 255 - a; c = 1'b1; m = 6'h1F; end
      11: begin
        t = 0 - a; r = t & 255; c = (r != 0);
        h = ((0 - (a & 15)) < 0);
        v = ((0 - sgn8(a)) > 127);
        m = 6'h3F;
      end
      12: begin r = (a + 1) & 255; v = ((sgn8(a) + 1) > 127);  m = 6'h1E; end
      13: begin r = (a - 1) & 255; v = ((sgn8(a) - 1) < -128); m = 6'h1E; end
      14: begin r = 255; m = 6'h00; end
      15, 16: begin r = 0; m = 6'h1F; end
      default: begin r = 0; m = 6'h00; end
    endcase
    z = (r == 0) && zChain;
    n = ((r >> 7) & 1) == 1;
    f = {h, n ^ v, v, n, z, c};
  endtask

  task automatic applyByte(input int op, input int a, input int b);
    int r;
    logic [5:0] f, m, expSt;
    string req;
    req = reqOf(op);
    model(op, a, b, st, r, f, m);
    expSt = (f & m) | (st & ~m);
    @(negedge clk);
    opValid = 1'b1; opSel = 5'(op); opA = 8'(a); opB = 8'(b);
    #1;
    check(req, "result/flags/mask", {12'h0, result, newFlags & m, flagMask},
          {12'h0, 8'(r), f & m, m});
    @(posedge clk); #1;
    check("R9", "status after edge", {26'h0, status}, {26'h0, expSt});
    check("R8", "status S vs N^V", {31'h0, status[4]}, {31'h0, status[3] ^ status[2]});
    st = expSt;
  endtask

  task automatic wordOp(input bit sub, input int a, input int b, input int k);
    int w, t, r, sw, sv;
    logic c, v, z, n;
    logic [5:0] expSt;
    w = b * 256 + a;
    sw = (w > 32767) ? w - 65536 : w;
    if (!sub) begin
      t = w + k; c = (t > 65535); sv = sw + k; v = (sv > 32767);
    end else begin
      t = w - k; c = (t < 0); sv = sw - k; v = (sv < -32768);
    end
    r = t & 65535;
    z = (r == 0);
    n = ((r >> 15) & 1) == 1;
    expSt = {st[5], n ^ v, v, n, z, c};
    @(negedge clk);
    opValid = 1'b1; opSel = sub ? 5'd16 : 5'd15; opA = 8'(a); opB = 8'(b); wordImm = 6'(k);
    #1;
    check("R9", "word mask", {26'h0, flagMask}, 32'h1F);
    @(posedge clk); #1;
    check("R10", "busy/done after accept", {30'h0, busy, wordDone}, 32'h2);
    check("R10", "status held at accept", {26'h0, status}, {26'h0, st});
    @(negedge clk);
    opValid = 1'b1; opSel = 5'd10; opA = 8'h00;   // must be ignored while busy
    @(posedge clk); #1;
    check("R10", "busy/done after second pass", {30'h0, busy, wordDone}, 32'h1);
    check("R10", "word result", {16'h0, wordResult}, {16'h0, 16'(r)});
    check("R11", "word flags (R12 ignore)", {26'h0, status}, {26'h0, expSt});
    st = expSt;
    @(negedge clk);
    opValid = 1'b0;
    @(posedge clk); #1;
    check("R10", "done pulse ends", {31'h0, wordDone}, 32'h0);
    check("R13", "idle status held", {26'h0, status}, {26'h0, st});
  endtask

  function automatic int bVal(input int a, input int j);
    case (j)
      0: return 0;
      1: return 1;
      2: return 8'h0F;
      3: return 8'h10;
      4: return 8'h7F;
      5: return 8'h80;
      6: return 8'hFE;
      7: return 8'hFF;
      default: return (a * 37 + j * 53 + 11) & 255;
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9", "reset state", {7'h0, status, busy, wordDone, wordResult},
          {7'h0, 6'h00, 1'b0, 1'b0, 16'h0000});
    @(negedge clk);
    rstN = 1'b1;
    st = '0;

    // zero chaining through carry-subtract
    applyByte(10, 8'hFF, 0);   // result 0: Z=1, C=1
    applyByte(3, 5, 4);        // 5-4-1 = 0, Z stays set (R2)
    applyByte(2, 1, 0);        // Z cleared
    applyByte(3, 0, 0);        // result 0 but Z stays clear (R2)

    // idle cycle leaves status alone
    @(negedge clk);
    opValid = 1'b0; opSel = 5'd0; opA = 8'hFF; opB = 8'h01;
    @(posedge clk); #1;
    check("R13", "idle byte cycle", {26'h0, status}, {26'h0, st});

    for (int op = 0; op < 15; op++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 16; j++)
          applyByte(op, a, bVal(a, j));

    for (int op = 17; op < 32; op++) begin
      applyByte(op, 8'hA5, 8'h3C);
      applyByte(op, 8'h00, 8'hFF);
    end

    // word corners
    wordOp(1'b0, 8'h00, 8'h00, 0);
    wordOp(1'b0, 8'hFF, 8'hFF, 1);
    wordOp(1'b0, 8'hFF, 8'h7F, 1);
    wordOp(1'b0, 8'hFF, 8'h00, 1);
    wordOp(1'b0, 8'hC1, 8'hFF, 63);
    wordOp(1'b1, 8'h00, 8'h00, 1);
    wordOp(1'b1, 8'h00, 8'h80, 1);
    wordOp(1'b1, 8'h00, 8'h01, 1);
    wordOp(1'b1, 8'h01, 8'h00, 1);
    wordOp(1'b1, 8'h3F, 8'h00, 63);
    for (int i = 0; i < 3000; i++)
      wordOp(1'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
             int'($urandom_range(0, 255)), int'($urandom_range(0, 63)));

    opValid = 1'b0;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog all requirements: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule